// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block erases part or all of a parallel NOR flash device through a simple memory-bus master port. A one-cycle start pulse captures four things: the target address, the requested erase scope (sector, block or whole chip), the command-set family and the data bus width. The block then issues a fixed run of six command writes. The first five unlock and arm the erase. The sixth selects the scope.

After the last write, the block reads the status word repeatedly. It stops when the toggle bit no longer changes between two consecutive reads. Under family A, it also stops if the timeout bit appears and the next read still toggles. In both cases it reports the result with a one-cycle done pulse, and the error flag marks a failed erase.

Unlock addresses are scaled to the byte width of the bus. Command bytes are copied onto every active byte lane. If the selected family does not support the requested scope, the block quietly performs a sector erase instead.

Top module: `flash_erase_seq`

## Requirements
- R1: A start in idle produces exactly six writes. The first five are, in order: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA (addresses shown for an 8-bit bus). For a sector erase the sixth write puts 0x30 at the target address.
- R2: The sixth write depends on the effective scope. A chip erase writes 0x10 to the scaled 0x555 address. A block erase writes 0x50 to the target address.
- R3: Scope falls back to sector when the family does not support the request. Chip erase is accepted only by families A (code 0) and B (code 1). Block erase is accepted only by family B. Codes 2 and 3 accept sector erase only.
- R4: The width select works as follows: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. The unlock addresses are shifted left by 0, 1 or 2. The command byte fills 1, 2 or 4 low byte lanes, and the remaining lanes are zero.
- R5: Each strobe (write or read, never both) holds a stable address until ready is sampled high. It is low in the following cycle.
- R6: Status is read from the target address. The first read only records bit 6. Done pulses, with the error flag low, on the first later read whose bit 6 equals bit 6 of the read before it.
- R7: Under family A, suppose a read toggles bit 6 with bit 5 set, and the next read toggles again. Then done and error pulse together after that next read.
- R8: Under family A, suppose a read toggles with bit 5 set, and the next read does not toggle. Then the erase completes with no error.
- R9: Families other than A ignore bit 5. Polling continues until bit 6 settles, and the error flag stays low.
- R10: After reset both strobes, done and error are low. A start pulse while a sequence is in flight has no effect on the write run.
- R11: Done is high for exactly one cycle per erase. Error is only ever high together with done.
- R12: The scope request is decoded as 1 for chip and 2 for block. Codes 0 and 3 both select sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase (sampled in idle only) |
| erase_addr | input | ADDR_W | Sector or block address |
| mode_req | input | 2 | Requested scope code |
| family | input | 2 | Command-set family code |
| width_sel | input | 2 | Bus width code |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ready | input | 1 | Access accepted when high with a strobe |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Erase failure, valid with done |

## Verification
Two events can land in the same cycle: a start request and an erase that is already in flight. The bench raises start again partway through a slow write run, using a different scope and family. It then checks that the logged writes are still exactly the six of the first request. A second collision happens when ready arrives in the first cycle of a strobe while the sequencer would also advance its step. Zero-wait rows in the table provoke this. The bus model then checks that every strobe drops for one cycle and that its address held steady while waiting.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [1:0] {
        FAM_A = 2'd0,
        FAM_B = 2'd1,
        FAM_C = 2'd2,
        FAM_D = 2'd3
    } fam_e;

    typedef enum logic [1:0] {
        EM_SECTOR = 2'd0,
        EM_CHIP   = 2'd1,
        EM_BLOCK  = 2'd2
    } emode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WGAP,
        ST_RD,
        ST_RGAP
    } st_e;

    localparam int unsigned N_CMD   = 6;
    localparam logic [11:0] UNLK_HI = 12'h555;
    localparam logic [11:0] UNLK_LO = 12'h2AA;

    function automatic logic [1:0] width_shift(input logic [1:0] sel);
        return (sel >= 2'd2) ? 2'd2 : sel;
    endfunction

    function automatic emode_e decode_req(input logic [1:0] r);
        case (r)
            2'd1:    return EM_CHIP;
            2'd2:    return EM_BLOCK;
            default: return EM_SECTOR;
        endcase
    endfunction

    function automatic logic [7:0] final_byte(input emode_e m);
        case (m)
            EM_CHIP:  return 8'h10;
            EM_BLOCK: return 8'h50;
            default:  return 8'h30;
        endcase
    endfunction

endpackage

// File: rtl/fe_mode_resolve.sv
module fe_mode_resolve
    import fe_pkg::*;
(
    input  fam_e        fam,
    input  logic [1:0]  req,
    output emode_e      eff
);
    emode_e want;

    always_comb begin
        want = decode_req(req);
        eff  = EM_SECTOR;
        case (want)
            EM_CHIP:  eff = (fam == FAM_A || fam == FAM_B) ? EM_CHIP : EM_SECTOR;
            EM_BLOCK: eff = (fam == FAM_B) ? EM_BLOCK : EM_SECTOR;
            default:  eff = EM_SECTOR;
        endcase
    end
endmodule

// File: rtl/fe_cmd_gen.sv
module fe_cmd_gen
    import fe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic [2:0]        step,
    input  emode_e            mode,
    input  logic [1:0]        sh,
    input  logic [ADDR_W-1:0] tgt,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] hi_a, lo_a;
    logic [7:0]        cbyte;

    assign hi_a = ADDR_W'(UNLK_HI) << sh;
    assign lo_a = ADDR_W'(UNLK_LO) << sh;

    always_comb begin
        case (step)
            3'd0:    begin addr = hi_a; cbyte = 8'hAA; end
            3'd1:    begin addr = lo_a; cbyte = 8'h55; end
            3'd2:    begin addr = hi_a; cbyte = 8'h80; end
            3'd3:    begin addr = hi_a; cbyte = 8'hAA; end
            3'd4:    begin addr = lo_a; cbyte = 8'h55; end
            default: begin
                addr  = (mode == EM_CHIP) ? hi_a : tgt;
                cbyte = final_byte(mode);
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data[g*8 +: 8] = (32'(g) < (32'd1 << sh)) ? cbyte : 8'h00;
    end
endmodule

// File: rtl/fe_status_eval.sv
module fe_status_eval
    import fe_pkg::*;
(
    input  logic       prev_tog,
    input  logic       cur_tog,
    input  logic       cur_tmo,
    input  fam_e       fam,
    input  logic       pend,
    output logic       settled,
    output logic       fail,
    output logic       arm
);
    logic moving;

    assign moving  = cur_tog ^ prev_tog;
    assign settled = !moving;
    assign fail    = moving && pend;
    assign arm     = moving && (fam == FAM_A) && cur_tmo;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] erase_addr,
    input  logic [1:0]        mode_req,
    input  logic [1:0]        family,
    input  logic [1:0]        width_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              done,
    output logic              error
);
    localparam logic [2:0] LAST_STEP = 3'(N_CMD - 1);

    st_e               st;
    logic [2:0]        step;
    emode_e            mode_q, mode_in;
    fam_e              fam_q;
    logic [1:0]        sh_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              prev_q, first_q, pend_q;
    logic              done_q, err_q;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              settled, fail, arm;
    logic              unused_rd;

    assign unused_rd = ^{bus_rdata[DATA_W-1:7], bus_rdata[4:0]};

    fe_mode_resolve u_res (
        .fam (fam_e'(family)),
        .req (mode_req),
        .eff (mode_in)
    );

    fe_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .step (step),
        .mode (mode_q),
        .sh   (sh_q),
        .tgt  (tgt_q),
        .addr (cmd_addr),
        .data (cmd_data)
    );

    fe_status_eval u_eval (
        .prev_tog (prev_q),
        .cur_tog  (bus_rdata[6]),
        .cur_tmo  (bus_rdata[5]),
        .fam      (fam_q),
        .pend     (pend_q),
        .settled  (settled),
        .fail     (fail),
        .arm      (arm)
    );

    assign bus_wr    = (st == ST_WR);
    assign bus_rd    = (st == ST_RD);
    assign bus_addr  = (st == ST_RD || st == ST_RGAP) ? tgt_q : cmd_addr;
    assign bus_wdata = cmd_data;
    assign done      = done_q;
    assign error     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            step    <= '0;
            mode_q  <= EM_SECTOR;
            fam_q   <= FAM_A;
            sh_q    <= '0;
            tgt_q   <= '0;
            prev_q  <= 1'b0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= mode_in;
                        fam_q  <= fam_e'(family);
                        sh_q   <= width_shift(width_sel);
                        tgt_q  <= erase_addr;
                        step   <= '0;
                        st     <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (bus_ready) st <= ST_WGAP;
                end
                ST_WGAP: begin
                    if (step == LAST_STEP) begin
                        first_q <= 1'b1;
                        pend_q  <= 1'b0;
                        st      <= ST_RD;
                    end else begin
                        step <= step + 3'd1;
                        st   <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (bus_ready) begin
                        if (first_q) begin
                            prev_q  <= bus_rdata[6];
                            first_q <= 1'b0;
                            st      <= ST_RGAP;
                        end else if (settled) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else if (fail) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            pend_q <= arm;
                            prev_q <= bus_rdata[6];
                            st     <= ST_RGAP;
                        end
                    end
                end
                ST_RGAP: st <= ST_RD;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fe_seq_checker.sv
module fe_seq_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_ready,
    input logic              done,
    input logic              error
);
    // R5: a write and a read are never requested together
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_wr, bus_rd}));

    // R5: an unanswered strobe stays up with the same address
    a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_ready) |=> ((bus_wr || bus_rd) && $stable(bus_addr)));

    // R5: strobes drop in the cycle after acceptance
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_ready) |=> (!bus_wr && !bus_rd));

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: error only alongside done
    a_r11_error_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R10: no strobe while done is reported
    a_r10_quiet_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_wr && !bus_rd));
endmodule

bind flash_erase_seq fe_seq_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready),
    .done      (done),
    .error     (error)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] erase_addr = '0;
    logic [1:0]    mode_req = '0, family = '0, width_sel = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wr, bus_rd;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          done, error;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    flash_erase_seq #(.ADDR_W(AW), .DATA_W(DW)) i_flash_erase_seq (
        .clk(clk), .rst(rst), .start(start), .erase_addr(erase_addr),
        .mode_req(mode_req), .family(family), .width_sel(width_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .done(done), .error(error)
    );

    typedef struct packed {
        logic [1:0]  fam;
        logic [1:0]  mode;
        logic [1:0]  wid;
        logic [23:0] addr;
        logic [1:0]  lat;
        logic [31:0] stat;   // byte k is the status of read k
        logic [2:0]  nst;
        logic [31:0] x_data;
        logic [23:0] x_addr;
        logic        x_err;
        logic [3:0]  x_reads;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        // R1 R6: family A sector, toggles once then settles
        '{2'd0, 2'd0, 2'd0, 24'h001000, 2'd0, 32'h00404000, 3'd3, 32'h00000030, 24'h001000, 1'b0, 4'd3},
        // R2: chip erase on family A
        '{2'd0, 2'd1, 2'd0, 24'h001000, 2'd1, 32'h00000000, 3'd2, 32'h00000010, 24'h000555, 1'b0, 4'd2},
        // R2 R4: block erase, family B, 16-bit bus
        '{2'd1, 2'd2, 2'd1, 24'h020000, 2'd2, 32'h40400040, 3'd4, 32'h00005050, 24'h020000, 1'b0, 4'd4},
        // R3: chip request on family code 2 falls back
        '{2'd2, 2'd1, 2'd0, 24'h003000, 2'd0, 32'h00000000, 3'd2, 32'h00000030, 24'h003000, 1'b0, 4'd2},
        // R3 R4: block request on family A falls back, 32-bit bus
        '{2'd0, 2'd2, 2'd2, 24'h004000, 2'd3, 32'h00000000, 3'd2, 32'h30303030, 24'h004000, 1'b0, 4'd2},
        // R12: request code 3 means sector
        '{2'd0, 2'd3, 2'd0, 24'h005000, 2'd0, 32'h00000000, 3'd2, 32'h00000030, 24'h005000, 1'b0, 4'd2},
        // R7: timeout bit then still toggling
        '{2'd0, 2'd0, 2'd0, 24'h006000, 2'd1, 32'h00206000, 3'd3, 32'h00000030, 24'h006000, 1'b1, 4'd3},
        // R8: timeout bit then settled
        '{2'd0, 2'd0, 2'd0, 24'h007000, 2'd0, 32'h00606000, 3'd3, 32'h00000030, 24'h007000, 1'b0, 4'd3},
        // R9: family B ignores timeout bit
        '{2'd1, 2'd0, 2'd0, 24'h008000, 2'd2, 32'h20206000, 3'd4, 32'h00000030, 24'h008000, 1'b0, 4'd4},
        // R4: width code 3 is 32-bit, chip on family B
        '{2'd1, 2'd1, 2'd3, 24'h009000, 2'd0, 32'h00000000, 3'd2, 32'h10101010, 24'h001554, 1'b0, 4'd2}
    };

    // bus model state
    int            lat_cur = 0, cnt = 0, wcnt = 0, ridx = 0;
    int            gap_err = 0, hold_err = 0;
    logic [31:0]   stat_cur = '0;
    int            nst_cur = 1;
    logic [AW-1:0] held;
    logic [AW-1:0] wa [8];
    logic [DW-1:0] wd [8];
    logic          stop_all = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                bus_ready = 1'b0;
                cnt = 0;
            end else if (bus_ready) begin
                bus_ready = 1'b0;
                if (bus_wr || bus_rd) gap_err++;
            end else if (bus_wr || bus_rd) begin
                if (cnt > 0 && bus_addr != held) hold_err++;
                held = bus_addr;
                if (cnt >= lat_cur) begin
                    bus_ready = 1'b1;
                    cnt = 0;
                    if (bus_wr) begin
                        if (wcnt < 8) begin
                            wa[wcnt] = bus_addr;
                            wd[wcnt] = bus_wdata;
                        end
                        wcnt++;
                    end else begin
                        bus_rdata = {24'h0, stat_cur[8*((ridx < nst_cur) ? ridx : nst_cur-1) +: 8]};
                        ridx++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] shf(input logic [1:0] w);
        return (w >= 2) ? 2'd2 : w;
    endfunction

    function automatic logic [31:0] repl(input logic [7:0] b, input logic [1:0] s);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) if (k < (1 << s)) r[8*k +: 8] = b;
        return r;
    endfunction

    task automatic pulse_start(input logic [1:0] f, input logic [1:0] m, input logic [1:0] w, input logic [AW-1:0] a);
        @(negedge clk);
        family = f; mode_req = m; width_sel = w; erase_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok, output logic err);
        ok = 1'b0; err = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; err = error; break; end
        end
    endtask

    task automatic check_unlock(input logic [1:0] w);
        logic [7:0]    bytes [5] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
        logic [AW-1:0] ea;
        logic [1:0]    s = shf(w);
        for (int k = 0; k < 5; k++) begin
            ea = ((k == 1 || k == 4) ? AW'(12'h2AA) : AW'(12'h555)) << s;
            check(wa[k] == ea, "R1 R4 unlock address", 32'(wa[k]), 32'(ea));
            check(wd[k] == repl(bytes[k], s), "R1 R4 unlock data", wd[k], repl(bytes[k], s));
        end
    endtask

    initial begin
        bit   ok;
        logic e;
        repeat (3) @(negedge clk);
        check(!bus_wr && !bus_rd && !done && !error, "R10 reset outputs",
              {28'h0, bus_wr, bus_rd, done, error}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_wr && !bus_rd, "R10 idle after reset", {30'h0, bus_wr, bus_rd}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            lat_cur = int'(VT[v].lat); stat_cur = VT[v].stat; nst_cur = int'(VT[v].nst);
            wcnt = 0; ridx = 0;
            pulse_start(VT[v].fam, VT[v].mode, VT[v].wid, VT[v].addr);
            wait_done(ok, e);
            check(ok, "R6 done seen", 32'(ok), 32'h1);
            check(wcnt == 6, "R1 write count", 32'(wcnt), 32'd6);
            check_unlock(VT[v].wid);
            check(wd[5] == VT[v].x_data, "R2 R3 sixth data", wd[5], VT[v].x_data);
            check(wa[5] == VT[v].x_addr, "R2 R3 sixth address", 32'(wa[5]), 32'(VT[v].x_addr));
            check(e == VT[v].x_err, "R7 R8 R9 error flag", 32'(e), 32'(VT[v].x_err));
            check(ridx == int'(VT[v].x_reads), "R6 status read count", 32'(ridx), 32'(VT[v].x_reads));
            @(negedge clk);
            check(!done && !error, "R11 done single pulse", {30'h0, done, error}, 32'h0);
        end

        // R10: start while busy is ignored
        lat_cur = 3; stat_cur = 32'h0; nst_cur = 1; wcnt = 0; ridx = 0;
        pulse_start(2'd0, 2'd0, 2'd0, 24'h00A000);
        repeat (6) @(negedge clk);
        pulse_start(2'd1, 2'd2, 2'd2, 24'h0BB000);
        wait_done(ok, e);
        check(ok && wcnt == 6, "R10 busy start write count", 32'(wcnt), 32'd6);
        check(wd[5] == 32'h30 && wa[5] == 24'h00A000, "R10 busy start sixth write", wd[5], 32'h30);
        @(negedge clk);
        check(!bus_wr && !bus_rd, "R10 no second run", {30'h0, bus_wr, bus_rd}, 32'h0);

        check(gap_err == 0, "R5 strobe release", 32'(gap_err), 32'h0);
        check(hold_err == 0, "R5 address hold", 32'(hold_err), 32'h0);

        stop_all = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!stop_all) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule